// File: doc/BRIEF.md
# Debug Command Enable Gate

This block sits between a JTAG-style instruction register and the debug logic it drives. Each time the test access port controller passes through Update-IR, the block captures the raw command code and registers an effective command. While debug access is enabled, every code passes unchanged. While it is disabled, only bypass, ID and the enable command get through, and any other code becomes bypass. From the effective command the block decodes one-hot data-path selects. It also opens the status-register read path, the control-register write path and the external debug-request line only while access is enabled.

The debug-enable input is a slow, security-driven level. The block accepts it only while the controller is in Test-Logic-Reset, Run-Test/Idle or Update-DR. A value seen in any other state is ignored. An accepted value passes through one more test-clock register before it takes effect, and `en_status` shows the enable in force. The `sel_enable` output marks that the enable command is selected, so external security logic can follow the enable handshake. Reset is synchronous and active high.

Top module: `dbg_cmd_gate`

## Requirements
- R1: After reset, `eff_cmd` is 0xFF (bypass), `en_status` is 0, `sel_bypass` is 1, and `status_rd`, `ctrl_wr` and `dbg_req_out` are 0.
- R2: With `en_status` low, a code loaded on Update-IR becomes `eff_cmd` unchanged only if it is 0xFF (bypass), 0x02 (ID) or 0x06 (enable). Every other code becomes 0xFF.
- R3: With `en_status` high, any code loaded on Update-IR appears unchanged on `eff_cmd`. `eff_cmd` is registered and shows the new code after the clock edge at which `tap_state` is Update-IR (4'hD).
- R4: `status_rd` is 1 only when `en_status` is 1 and `eff_cmd` is 0x11 (status register). It is 0 otherwise, even if that code was latched earlier.
- R5: `ctrl_wr` is 1 only when `en_status` is 1 and `eff_cmd` is 0x12 (control register).
- R6: `dbg_req_out` follows `dbg_req_in` while `en_status` is 1 and is 0 while `en_status` is 0.
- R7: `dbg_en_in` is sampled only when `tap_state` is Test-Logic-Reset (4'hF), Run-Test/Idle (4'hC) or Update-DR (4'h5). A change seen in any other state leaves `en_status` unchanged.
- R8: A value of `dbg_en_in` sampled at a clock edge in a permitted state appears on `en_status` after the following clock edge. It does not appear after the sampling edge itself.
- R9: Exactly one of `sel_bypass`, `sel_idcode`, `sel_enable`, `sel_regacc` is high. `sel_idcode` marks 0x02, `sel_enable` marks 0x06, and `sel_regacc` marks 0x10..0x1F while enabled. Any other code, including unknown codes passed while enabled, selects bypass.
- R10: When `en_status` falls, a latched `eff_cmd` outside the always-allowed set is replaced by 0xFF on the next clock edge, without a new Update-IR.
- R11: Outside Update-IR, a change of `cmd_raw` does not change `eff_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_state | input | 4 | Current controller state code |
| cmd_raw | input | 8 | Command code from the instruction register |
| dbg_en_in | input | 1 | Debug-enable level |
| dbg_req_in | input | 1 | External debug request |
| eff_cmd | output | 8 | Registered effective command |
| sel_bypass | output | 1 | Bypass path selected |
| sel_idcode | output | 1 | ID path selected |
| sel_enable | output | 1 | Enable command selected |
| sel_regacc | output | 1 | Debug register access selected |
| status_rd | output | 1 | Status-register read permitted |
| ctrl_wr | output | 1 | Control-register function permitted |
| dbg_req_out | output | 1 | Gated debug request |
| en_status | output | 1 | Enable currently in force |

## Verification
The hardest case to reach is losing the enable while a register-access command is latched. The status or control path must close at once, and the latched code must fall back to bypass with no further Update-IR. The bench enables access, loads the control code, drops the enable in Run-Test/Idle, and checks each cycle as it passes. It also toggles the enable only while the state is Shift-DR and confirms that nothing changes over several cycles. A second check confirms that the synchronizing register adds exactly one cycle.

// File: rtl/dbgate_pkg.sv
package dbgate_pkg;

    localparam int CMD_W = 8;

    typedef logic [CMD_W-1:0] cmd_t;

    localparam cmd_t CMD_BYPASS = 8'hFF;
    localparam cmd_t CMD_IDCODE = 8'h02;
    localparam cmd_t CMD_ENABLE = 8'h06;
    localparam cmd_t CMD_REG_LO = 8'h10;
    localparam cmd_t CMD_REG_HI = 8'h1F;
    localparam cmd_t CMD_STATUS = 8'h11;
    localparam cmd_t CMD_CTRL   = 8'h12;

    typedef enum logic [3:0] {
        TS_EXIT2_DR = 4'h0,
        TS_EXIT1_DR = 4'h1,
        TS_SHIFT_DR = 4'h2,
        TS_PAUSE_DR = 4'h3,
        TS_SEL_IR   = 4'h4,
        TS_UPD_DR   = 4'h5,
        TS_CAP_DR   = 4'h6,
        TS_SEL_DR   = 4'h7,
        TS_EXIT2_IR = 4'h8,
        TS_EXIT1_IR = 4'h9,
        TS_SHIFT_IR = 4'hA,
        TS_PAUSE_IR = 4'hB,
        TS_RTI      = 4'hC,
        TS_UPD_IR   = 4'hD,
        TS_CAP_IR   = 4'hE,
        TS_TLR      = 4'hF
    } tap_state_e;

    typedef struct packed {
        logic bypass;
        logic idcode;
        logic enable;
        logic regacc;
    } path_sel_t;

    function automatic logic en_window(tap_state_e s);
        return (s == TS_TLR) || (s == TS_RTI) || (s == TS_UPD_DR);
    endfunction

    function automatic logic always_allowed(cmd_t c);
        return (c == CMD_BYPASS) || (c == CMD_IDCODE) || (c == CMD_ENABLE);
    endfunction

    function automatic cmd_t gate_cmd(cmd_t c, logic en);
        return (en || always_allowed(c)) ? c : CMD_BYPASS;
    endfunction

    function automatic logic in_reg_range(cmd_t c);
        return (c >= CMD_REG_LO) && (c <= CMD_REG_HI);
    endfunction

endpackage

// File: rtl/dbgate_en_sync.sv
module dbgate_en_sync
    import dbgate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tap_state_e state,
    input  logic       en_raw,
    output logic       en_eff
);

    logic en_capt;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_capt <= 1'b0;
        end else if (en_window(state)) begin
            en_capt <= en_raw;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_eff <= 1'b0;
        end else begin
            en_eff <= en_capt;
        end
    end

endmodule

// File: rtl/dbgate_cmd_reg.sv
module dbgate_cmd_reg
    import dbgate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tap_state_e state,
    input  cmd_t       cmd_in,
    input  logic       en_eff,
    output cmd_t       cmd_q
);

    cmd_t cmd_d;

    always_comb begin
        cmd_d = cmd_q;
        if (state == TS_UPD_IR) begin
            cmd_d = gate_cmd(cmd_in, en_eff);
        end else if (!en_eff) begin
            cmd_d = gate_cmd(cmd_q, 1'b0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= CMD_BYPASS;
        end else begin
            cmd_q <= cmd_d;
        end
    end

endmodule

// File: rtl/dbgate_access_mask.sv
module dbgate_access_mask
    import dbgate_pkg::*;
(
    input  cmd_t      cmd,
    input  logic      en_eff,
    input  logic      req_in,
    output path_sel_t path,
    output logic      status_rd,
    output logic      ctrl_wr,
    output logic      req_out
);

    always_comb begin
        path.idcode = (cmd == CMD_IDCODE);
        path.enable = (cmd == CMD_ENABLE);
        path.regacc = en_eff && in_reg_range(cmd);
        path.bypass = !(path.idcode || path.enable || path.regacc);
    end

    assign status_rd = path.regacc && (cmd == CMD_STATUS);
    assign ctrl_wr   = path.regacc && (cmd == CMD_CTRL);
    assign req_out   = en_eff && req_in;

endmodule

// File: rtl/dbg_cmd_gate.sv
module dbg_cmd_gate
    import dbgate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       tap_state,
    input  logic [CMD_W-1:0] cmd_raw,
    input  logic             dbg_en_in,
    input  logic             dbg_req_in,
    output logic [CMD_W-1:0] eff_cmd,
    output logic             sel_bypass,
    output logic             sel_idcode,
    output logic             sel_enable,
    output logic             sel_regacc,
    output logic             status_rd,
    output logic             ctrl_wr,
    output logic             dbg_req_out,
    output logic             en_status
);

    tap_state_e state;
    logic       en_eff;
    cmd_t       cmd_q;
    path_sel_t  path;

    assign state = tap_state_e'(tap_state);

    dbgate_en_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .state  (state),
        .en_raw (dbg_en_in),
        .en_eff (en_eff)
    );

    dbgate_cmd_reg u_cmd (
        .clk    (clk),
        .rst    (rst),
        .state  (state),
        .cmd_in (cmd_raw),
        .en_eff (en_eff),
        .cmd_q  (cmd_q)
    );

    dbgate_access_mask u_mask (
        .cmd       (cmd_q),
        .en_eff    (en_eff),
        .req_in    (dbg_req_in),
        .path      (path),
        .status_rd (status_rd),
        .ctrl_wr   (ctrl_wr),
        .req_out   (dbg_req_out)
    );

    assign eff_cmd    = cmd_q;
    assign sel_bypass = path.bypass;
    assign sel_idcode = path.idcode;
    assign sel_enable = path.enable;
    assign sel_regacc = path.regacc;
    assign en_status  = en_eff;

endmodule

// File: rtl/dbg_cmd_gate_chk.sv
module dbg_cmd_gate_chk
    import dbgate_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [3:0]       tap_state,
    input logic [CMD_W-1:0] cmd_raw,
    input logic             dbg_en_in,
    input logic             dbg_req_in,
    input logic [CMD_W-1:0] eff_cmd,
    input logic             sel_bypass,
    input logic             sel_idcode,
    input logic             sel_enable,
    input logic             sel_regacc,
    input logic             status_rd,
    input logic             ctrl_wr,
    input logic             dbg_req_out,
    input logic             en_status
);

    // R2
    locked_load_chk: assert property (@(posedge clk) disable iff (rst)
        (tap_state == 4'hD && !en_status) |=> always_allowed(eff_cmd));

    // R4
    status_gate_chk: assert property (@(posedge clk) disable iff (rst)
        status_rd |-> (en_status && eff_cmd == CMD_STATUS));

    // R5
    ctrl_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |-> (en_status && eff_cmd == CMD_CTRL));

    // R6
    req_gate_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_req_out |-> (dbg_req_in && en_status));

    // R7
    en_window_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_window(tap_state_e'(tap_state)) && !en_window(tap_state_e'($past(tap_state))))
        |=> $stable(en_status));

    // R8
    en_latency_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(en_status) |-> ($past(dbg_en_in, 2) && en_window(tap_state_e'($past(tap_state, 2)))));

    // R9
    path_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({sel_bypass, sel_idcode, sel_enable, sel_regacc}) == 1);

    // R11
    hold_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (tap_state != 4'hD && en_status) |=> $stable(eff_cmd));

endmodule

bind dbg_cmd_gate dbg_cmd_gate_chk u_chk (.*);

// File: tb/tb_dbg_cmd_gate.sv
module tb_dbg_cmd_gate;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] tap_state;
    logic [7:0] cmd_raw;
    logic       dbg_en_in;
    logic       dbg_req_in;
    logic [7:0] eff_cmd;
    logic       sel_bypass, sel_idcode, sel_enable, sel_regacc;
    logic       status_rd, ctrl_wr, dbg_req_out, en_status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [3:0] ST_TLR = 4'hF, ST_RTI = 4'hC, ST_UDR = 4'h5,
                           ST_UIR = 4'hD, ST_SDR = 4'h2;

    always #5 clk = ~clk;

    dbg_cmd_gate dut (
        .clk(clk), .rst(rst), .tap_state(tap_state), .cmd_raw(cmd_raw),
        .dbg_en_in(dbg_en_in), .dbg_req_in(dbg_req_in), .eff_cmd(eff_cmd),
        .sel_bypass(sel_bypass), .sel_idcode(sel_idcode), .sel_enable(sel_enable),
        .sel_regacc(sel_regacc), .status_rd(status_rd), .ctrl_wr(ctrl_wr),
        .dbg_req_out(dbg_req_out), .en_status(en_status)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_cmd(logic [7:0] c);
        tap_state = ST_UIR;
        cmd_raw = c;
        tick();
        tap_state = ST_RTI;
    endtask

    task automatic set_en(logic v);
        tap_state = ST_RTI;
        dbg_en_in = v;
        tick();
        tick();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tap_state = ST_TLR;
        cmd_raw = 8'h00;
        dbg_en_in = 1'b0;
        dbg_req_in = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        chk("R1 eff_cmd", eff_cmd, 8'hFF);
        chk("R1 en_status", {7'b0, en_status}, 8'h00);
        chk("R1 sel_bypass", {7'b0, sel_bypass}, 8'h01);
        chk("R1 gates", {5'b0, status_rd, ctrl_wr, dbg_req_out}, 8'h00);
        dbg_req_in = 1'b0;
    endtask

    task automatic t_locked();
        load_cmd(8'h11);
        chk("R2 status code locked", eff_cmd, 8'hFF);
        chk("R4 status hidden", {7'b0, status_rd}, 8'h00);
        load_cmd(8'h02);
        chk("R2 idcode passes", eff_cmd, 8'h02);
        chk("R9 idcode sel", {sel_bypass, sel_idcode, sel_enable, sel_regacc}, 8'h04);
        load_cmd(8'h06);
        chk("R2 enable passes", eff_cmd, 8'h06);
        chk("R9 enable sel", {sel_bypass, sel_idcode, sel_enable, sel_regacc}, 8'h02);
        load_cmd(8'h40);
        chk("R2 unknown locked", eff_cmd, 8'hFF);
        dbg_req_in = 1'b1;
        #1;
        chk("R6 request masked", {7'b0, dbg_req_out}, 8'h00);
        dbg_req_in = 1'b0;
    endtask

    task automatic t_latency();
        tap_state = ST_RTI;
        dbg_en_in = 1'b1;
        tick();
        chk("R8 not after first edge", {7'b0, en_status}, 8'h00);
        tick();
        chk("R8 after second edge", {7'b0, en_status}, 8'h01);
    endtask

    task automatic t_open();
        load_cmd(8'h11);
        chk("R3 status code passes", eff_cmd, 8'h11);
        chk("R4 status visible", {7'b0, status_rd}, 8'h01);
        chk("R9 regacc sel", {sel_bypass, sel_idcode, sel_enable, sel_regacc}, 8'h01);
        load_cmd(8'h40);
        chk("R3 unknown passes", eff_cmd, 8'h40);
        chk("R9 unknown to bypass", {sel_bypass, sel_idcode, sel_enable, sel_regacc}, 8'h08);
        dbg_req_in = 1'b1;
        #1;
        chk("R6 request passes", {7'b0, dbg_req_out}, 8'h01);
        dbg_req_in = 1'b0;
        #1;
        chk("R6 request follows low", {7'b0, dbg_req_out}, 8'h00);
        load_cmd(8'h12);
        chk("R5 ctrl permitted", {7'b0, ctrl_wr}, 8'h01);
    endtask

    task automatic t_hold();
        tap_state = ST_SDR;
        cmd_raw = 8'h02;
        tick();
        tap_state = ST_RTI;
        cmd_raw = 8'h06;
        tick();
        chk("R11 eff_cmd held", eff_cmd, 8'h12);
    endtask

    task automatic t_window();
        tap_state = ST_SDR;
        dbg_en_in = 1'b0;
        repeat (4) tick();
        chk("R7 disable ignored", {7'b0, en_status}, 8'h01);
        dbg_en_in = 1'b1;
        tick();
        tap_state = ST_UDR;
        dbg_en_in = 1'b0;
        tick();
        tap_state = ST_SDR;
        dbg_en_in = 1'b1;
        tick();
        chk("R7 update-dr accepted", {7'b0, en_status}, 8'h00);
        tap_state = ST_TLR;
        tick();
        tick();
        chk("R7 tlr accepted", {7'b0, en_status}, 8'h01);
    endtask

    task automatic t_drop();
        load_cmd(8'h12);
        chk("R5 ctrl open before drop", {7'b0, ctrl_wr}, 8'h01);
        dbg_en_in = 1'b0;
        tap_state = ST_RTI;
        tick();
        chk("R10 still enabled", eff_cmd, 8'h12);
        tick();
        chk("R5 ctrl closed on drop", {7'b0, ctrl_wr}, 8'h00);
        tick();
        chk("R10 latched code to bypass", eff_cmd, 8'hFF);
        set_en(1'b1);
        load_cmd(8'h06);
        set_en(1'b0);
        tick();
        chk("R10 enable code kept", eff_cmd, 8'h06);
    endtask

    initial begin
        t_reset();
        t_locked();
        t_latency();
        t_open();
        t_hold();
        t_window();
        t_drop();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule